// File: doc/BRIEF.md
# Word Copy DMA Engine

This block moves a run of 32-bit words from one region of memory to another without the host touching the data. The host places a source base address, a destination base address and a word count on the command pins and raises the command strobe. The engine copies those three values into its own registers, answers with a one-cycle accept pulse, and then works through the words. For each word it reads from the source pointer, keeps the returned word in a holding register, and writes that word to the destination pointer. After each write both pointers advance by one word (4 bytes) and the count drops by one. When the count reaches zero the engine raises a one-cycle finished pulse and goes back to idle.

The memory side is a single request channel with valid/ready flow control. `mem_valid` is the request valid, `mem_ready` is the memory's acknowledge, and `mem_we` selects write (1) or read (0). Memory applies back-pressure by holding `mem_ready` low. While it does so, the engine keeps `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` unchanged. A transfer completes in the cycle where `mem_valid` and `mem_ready` are both high. Read data is taken from `mem_rdata` in that same cycle. The command pins are plain level inputs, and the engine looks at them only while it is idle.

Top module: `word_copy_dma`

## Requirements
- R1: After reset and in every idle cycle, `cmd_taken`, `xfer_done`, `mem_valid` and `mem_we` are 0, and `mem_addr` and `mem_wdata` are all zeros.
- R2: A clock edge that sees `cmd_valid` high while idle loads the command. `cmd_taken` is then high for exactly the next cycle and never at any other time.
- R3: A read request drives `mem_valid`=1, `mem_we`=0 and `mem_addr` equal to the current source pointer. The word on `mem_rdata` in the handshake cycle is the one kept.
- R4: A write request drives `mem_valid`=1, `mem_we`=1, `mem_addr` equal to the current destination pointer and `mem_wdata` equal to the kept word. Every request holds all of these stable for as long as `mem_ready` stays low.
- R5: After each write handshake there is exactly one cycle with `mem_valid`=0. The source and destination pointers then advance by 4 and the count by -1.
- R6: For a count N, words src+4*i are copied to dst+4*i for i in 0..N-1 in ascending order, alternating read then write. No address beyond the last word is written.
- R7: `xfer_done` is high for one cycle, 1+N*(2L+3) cycles after the `cmd_taken` cycle, where L is the number of stall cycles memory inserts before each acknowledge. The engine then returns to idle.
- R8: A count of 0 raises `xfer_done` in the cycle right after `cmd_taken` and issues no memory request. It does not wrap the count to 255.
- R9: `cmd_valid` and the command fields are ignored from the accept cycle through the finish cycle. The transfer in progress keeps its original addresses and count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_src | input | 32 | Source byte base address |
| cmd_dst | input | 32 | Destination byte base address |
| cmd_len | input | 8 | Number of words to copy |
| cmd_taken | output | 1 | One-cycle pulse when the command is loaded |
| xfer_done | output | 1 | One-cycle pulse when the copy completes |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Write enable (1 write, 0 read) |
| mem_ready | input | 1 | Memory acknowledge / ready |

## Verification
Two pairs of functions can fall in the same cycle here. The first pair is the command strobe and the finish pulse. The bench holds `cmd_valid` high, with different addresses and count, through the whole of a transfer including its `xfer_done` cycle. It judges that no second accept appears and that every memory address still follows the first command. The second pair is the read acknowledge and the start of the write. Here `mem_valid` stays high across the read-to-write boundary with no gap. Each handshake is checked against a reference pointer and data, at stall lengths of zero and several cycles.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LATCH,
    ST_READ,
    ST_WRITE,
    ST_STEP,
    ST_DONE
  } dma_state_t;
endpackage

// File: rtl/dma_ctrl_fsm.sv
module dma_ctrl_fsm
  import dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic       mem_ready,
  input  logic       cnt_zero,
  output dma_state_t st,
  output logic       load_cmd,
  output logic       rd_ack,
  output logic       wr_ack
);
  dma_state_t nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:  if (cmd_valid) nxt = ST_LATCH;
      ST_LATCH: nxt = cnt_zero ? ST_DONE : ST_READ;
      ST_READ:  if (mem_ready) nxt = ST_WRITE;
      ST_WRITE: if (mem_ready) nxt = ST_STEP;
      ST_STEP:  nxt = cnt_zero ? ST_DONE : ST_READ;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  assign load_cmd = (st == ST_IDLE) && cmd_valid;
  assign rd_ack   = (st == ST_READ) && mem_ready;
  assign wr_ack   = (st == ST_WRITE) && mem_ready;

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && st != ST_DONE) |=> (st != ST_LATCH));
endmodule

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_cmd,
  input  logic          rd_ack,
  input  logic          wr_ack,
  input  logic [AW-1:0] cmd_src,
  input  logic [AW-1:0] cmd_dst,
  input  logic [CW-1:0] cmd_len,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr,
  output logic [DW-1:0] hold_q,
  output logic          cnt_zero
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_ptr <= '0;
      dst_ptr <= '0;
      cnt_q   <= '0;
    end else if (load_cmd) begin
      src_ptr <= cmd_src;
      dst_ptr <= cmd_dst;
      cnt_q   <= cmd_len;
    end else if (wr_ack) begin
      src_ptr <= src_ptr + STEP;
      dst_ptr <= dst_ptr + STEP;
      cnt_q   <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      hold_q <= '0;
    else if (rd_ack) hold_q <= mem_rdata;
  end

  assign cnt_zero = (cnt_q == '0);

  // R3
  hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |=> (hold_q == $past(mem_rdata)));
  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> (dst_ptr - src_ptr == $past(dst_ptr) - $past(src_ptr)));
endmodule

// File: rtl/dma_mem_port.sv
module dma_mem_port
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  dma_state_t    st,
  input  logic [AW-1:0] src_ptr,
  input  logic [AW-1:0] dst_ptr,
  input  logic [DW-1:0] hold_q,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_valid,
  output logic          mem_we,
  output logic          cmd_taken,
  output logic          xfer_done
);
  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    unique case (st)
      ST_READ: begin
        mem_addr  = src_ptr;
        mem_valid = 1'b1;
      end
      ST_WRITE: begin
        mem_addr  = dst_ptr;
        mem_wdata = hold_q;
        mem_valid = 1'b1;
        mem_we    = 1'b1;
      end
      default: ;
    endcase
  end

  assign cmd_taken = (st == ST_LATCH);
  assign xfer_done = (st == ST_DONE);
endmodule

// File: rtl/word_copy_dma.sv
module word_copy_dma
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_src,
  input  logic [AW-1:0] cmd_dst,
  input  logic [CW-1:0] cmd_len,
  output logic          cmd_taken,
  output logic          xfer_done,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_valid,
  output logic          mem_we,
  input  logic          mem_ready
);
  dma_state_t    st;
  logic          load_cmd, rd_ack, wr_ack, cnt_zero;
  logic [AW-1:0] src_ptr, dst_ptr;
  logic [DW-1:0] hold_q;

  dma_ctrl_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .mem_ready(mem_ready),
    .cnt_zero(cnt_zero), .st(st), .load_cmd(load_cmd), .rd_ack(rd_ack),
    .wr_ack(wr_ack)
  );

  dma_xfer_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .load_cmd(load_cmd), .rd_ack(rd_ack),
    .wr_ack(wr_ack), .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_len(cmd_len),
    .mem_rdata(mem_rdata), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
    .hold_q(hold_q), .cnt_zero(cnt_zero)
  );

  dma_mem_port #(.AW(AW), .DW(DW)) u_port (
    .st(st), .src_ptr(src_ptr), .dst_ptr(dst_ptr), .hold_q(hold_q),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_valid(mem_valid),
    .mem_we(mem_we), .cmd_taken(cmd_taken), .xfer_done(xfer_done)
  );

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));
  // R5
  write_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && mem_ready) |=> !mem_valid);
  // R2
  taken_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_taken |=> !cmd_taken);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> (!xfer_done && !mem_valid && !mem_we && !cmd_taken &&
                   mem_addr == '0 && mem_wdata == '0));
  // R8
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_taken && cnt_zero) |=> (xfer_done && !mem_valid));
  // R3
  we_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_valid);
endmodule

// File: tb/test_word_copy_dma.sv
module test_word_copy_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_src = '0, cmd_dst = '0;
  logic [7:0]  cmd_len = '0;
  logic        cmd_taken, xfer_done, mem_valid, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0, fails = 0;
  int lat = 0;
  int wcnt = 0;
  logic fill_go = 1'b0;
  logic [31:0] mem [1024];
  bit finished_run = 1'b0;

  always #2 clk = ~clk;

  word_copy_dma i_word_copy_dma (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_src(cmd_src),
    .cmd_dst(cmd_dst), .cmd_len(cmd_len), .cmd_taken(cmd_taken),
    .xfer_done(xfer_done), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_ready(mem_ready)
  );

  function automatic logic [31:0] pat(input int i);
    logic [15:0] v = 16'(i);
    return {v ^ 16'hC3A5, ~v};
  endfunction

  assign mem_ready = mem_valid && (wcnt >= lat);
  assign mem_rdata = mem[mem_addr[11:2]];

  always @(posedge clk) begin
    if (!mem_valid || mem_ready) wcnt <= 0;
    else                         wcnt <= wcnt + 1;
    if (fill_go) begin
      for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
    end else if (mem_valid && mem_we && mem_ready) begin
      mem[mem_addr[11:2]] <= mem_wdata;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic fill_mem();
    @(negedge clk); fill_go = 1'b1;
    @(negedge clk); fill_go = 1'b0;
  endtask

  task automatic check_idle(input string req);
    check(!cmd_taken && !xfer_done && !mem_valid && !mem_we &&
          mem_addr == 0 && mem_wdata == 0, req, "idle outputs",
          {26'd0, cmd_taken, xfer_done, mem_valid, mem_we,
           |mem_addr, |mem_wdata}, 32'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");
  endtask

  // One command; optionally keep cmd_valid high with other fields (R9).
  task automatic t_copy(input logic [31:0] src, input logic [31:0] dst,
                        input int n, input int l, input bit hold);
    int rd_i = 0, wr_i = 0, cyc = 0, bad_taken = 0, bad_addr = 0;
    int exp_done = 1 + n * (2 * l + 3);
    bit gap_next = 1'b0, done_seen = 1'b0;
    fill_mem();
    lat = l;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_src = src; cmd_dst = dst; cmd_len = 8'(n);
    @(negedge clk);
    check(cmd_taken, "R2", "accept pulse", {31'd0, cmd_taken}, 32'd1);
    if (hold) begin
      cmd_src = 32'h10; cmd_dst = 32'hC00; cmd_len = 8'd7;
    end else cmd_valid = 1'b0;
    while (cyc < 4000) begin
      if (cyc > 0 && cmd_taken) bad_taken++;
      if (gap_next) begin
        check(!mem_valid, "R5", "gap after write", {31'd0, mem_valid}, 32'd0);
        gap_next = 1'b0;
      end
      if (mem_valid && mem_ready) begin
        if (!mem_we) begin
          if (mem_addr != src + 32'(4 * rd_i) || rd_i != wr_i) bad_addr++;
          check(mem_addr == src + 32'(4 * rd_i), "R3", "read address",
                mem_addr, src + 32'(4 * rd_i));
          rd_i++;
        end else begin
          check(mem_addr == dst + 32'(4 * wr_i) &&
                mem_wdata == pat(int'(src >> 2) + wr_i), "R4",
                "write addr/data", mem_wdata, pat(int'(src >> 2) + wr_i));
          wr_i++;
          gap_next = 1'b1;
        end
      end
      if (xfer_done) begin
        done_seen = 1'b1;
        check(cyc == exp_done, "R7", "done cycle", 32'(cyc), 32'(exp_done));
        cmd_valid = 1'b0;
        break;
      end
      @(negedge clk);
      cyc++;
    end
    check(done_seen && wr_i == n && rd_i == n, "R6", "word count",
          32'(wr_i), 32'(n));
    if (n == 0)
      check(done_seen && cyc == 1 && rd_i == 0, "R8", "zero length",
            32'(cyc), 32'd1);
    if (hold)
      check(bad_taken == 0 && bad_addr == 0, "R9", "command ignored busy",
            32'(bad_taken + bad_addr), 32'd0);
    @(negedge clk);
    check(!xfer_done, "R7", "done one cycle", {31'd0, xfer_done}, 32'd0);
    check_idle("R1");
    for (int i = 0; i < n; i++)
      check(mem[int'(dst >> 2) + i] == pat(int'(src >> 2) + i), "R6",
            "copied word", mem[int'(dst >> 2) + i], pat(int'(src >> 2) + i));
    check(mem[int'(dst >> 2) + n] == pat(int'(dst >> 2) + n), "R6",
          "word past end untouched", mem[int'(dst >> 2) + n],
          pat(int'(dst >> 2) + n));
  endtask

  initial begin
    t_reset();
    t_copy(32'h0000_0100, 32'h0000_0800, 1, 0, 1'b0);
    t_copy(32'h0000_0040, 32'h0000_0A00, 5, 0, 1'b0);
    t_copy(32'h0000_0020, 32'h0000_0900, 4, 3, 1'b0);
    t_copy(32'h0000_0000, 32'h0000_0C00, 0, 0, 1'b0);
    t_copy(32'h0000_0040, 32'h0000_0800, 3, 2, 1'b1);
    t_copy(32'h0000_0000, 32'h0000_0400, 255, 0, 1'b0);
    finished_run = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished_run) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule